// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a vector datapath that adds four-way byte dot products into 32-bit accumulator lanes. Each beat carries three vectors: a set of 32-bit accumulator lanes, a first byte vector and a second byte vector. For every lane, the block multiplies the four bytes that sit in that lane's slot of the first vector by the matching bytes of the second vector. It adds the four products to the lane's accumulator and writes the 32-bit lane result.

A two-bit operand-mode input sets how bytes are widened before multiplying. Each operand can be sign-extended or zero-extended. A one-bit saturation enable chooses between a wrapping sum and a sum clamped to the 32-bit range. The clamp range follows the operand mode. A width-select input chooses between the full vector and a narrow vector that uses only the low lanes. When the narrow vector is selected, all higher lanes are forced to zero.

Data moves through a valid/ready stream. A beat is taken on a rising clock edge where `in_valid` and `in_ready` are both high. In the registered build (`OUT_REG=1`), `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held and no new beat is taken. In the pass-through build (`OUT_REG=0`), the result is combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. Mode, saturation and width inputs are sampled together with the beat.

Top module: `pdp_dot_acc`

## Requirements
- R1: Lane j forms its products from bytes 4j, 4j+1, 4j+2 and 4j+3 of both byte vectors. Byte k of the first vector is paired only with byte k of the second, and no lane uses bytes from another lane's slot. Byte k occupies bits [8k+7:8k].
- R2: With `mode` = 2'b00, both bytes of every pair are treated as signed two's-complement values.
- R3: With `mode` = 2'b01, first-vector bytes are signed and second-vector bytes are unsigned.
- R4: With `mode` = 2'b10 or 2'b11, both bytes of every pair are unsigned.
- R5: With `sat_en` = 0, each lane result is the accumulator plus the four products, taken modulo 2^32.
- R6: With `sat_en` = 1 and `mode` 2'b00 or 2'b01, the accumulator is read as signed. The exact sum is clamped to the range 0x80000000 (most negative) through 0x7FFFFFFF (most positive).
- R7: With `sat_en` = 1 and `mode` 2'b10 or 2'b11, the accumulator is read as unsigned. A sum above 0xFFFFFFFF gives 0xFFFFFFFF.
- R8: With `wide` = 0, lanes NARROW_LANES and above are output as zero and the low lanes are computed normally. With `wide` = 1, all LANES lanes are computed.
- R9: A beat transfers when `in_valid` and `in_ready` are both high. In the registered build its result appears with `out_valid` high after the next rising edge, and `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change, even when a new beat is offered.
- R11: A synchronous active-high `rst` clears `out_valid`.
- R12: In the pass-through build, `out_data` carries the result of the current inputs in the same cycle, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| mode | input | 2 | Operand signedness: 00 s*s, 01 s*u, 10/11 u*u |
| sat_en | input | 1 | 1 = saturating sum, 0 = wrapping sum |
| wide | input | 1 | 1 = all lanes, 0 = low NARROW_LANES lanes only |
| acc_in | input | LANES*32 | Accumulator lanes, lane j at bits [32j+31:32j] |
| a_in | input | LANES*32 | First byte vector |
| b_in | input | LANES*32 | Second byte vector |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | LANES*32 | Result lanes, same layout as acc_in |

## Verification
The bench feeds byte values 0x80 and 0xFF against accumulators at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, in every mode with and without saturation. These cases expose a design that widens a byte with the wrong extension, cuts an unsigned product of 65025 to 16 bits, or clamps an unsigned sum with the signed bound. A signed-times-unsigned case with an accumulator of 0xFFFFFFFF shows whether the accumulator is read as -1 or as a large unsigned value. A narrow-width beat over nonzero upper operands catches lanes that leak past the active width. A stall that lasts several cycles while a second beat waits catches a register that overwrites its held result.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

  // Operand signedness selection, carried on the two-bit mode input.
  typedef enum logic [1:0] {
    OPM_SS  = 2'b00,
    OPM_SU  = 2'b01,
    OPM_UU  = 2'b10,
    OPM_UU2 = 2'b11
  } opmode_e;

  // The first operand and the accumulator are signed unless bit 1 is set.
  function automatic logic first_is_signed(input logic [1:0] m);
    return ~m[1];
  endfunction

  // The second operand is signed only in the both-signed mode.
  function automatic logic second_is_signed(input logic [1:0] m);
    return (m == OPM_SS);
  endfunction

endpackage

// File: rtl/pdp_lane.sv
module pdp_lane
  import pdp_pkg::*;
#(
  parameter int EL_W  = 8,
  parameter int EPL   = 4,
  parameter int ACC_W = 32
) (
  input  logic [1:0]          mode,
  input  logic                sat_en,
  input  logic                active,
  input  logic [ACC_W-1:0]    acc,
  input  logic [EPL*EL_W-1:0] a_bytes,
  input  logic [EPL*EL_W-1:0] b_bytes,
  output logic [ACC_W-1:0]    wrap_sum,
  output logic [ACC_W-1:0]    result
);

  // A widened byte is EL_W+1 bits; the product of two such bytes needs 2*EL_W+2 bits.
  localparam int PROD_W = 2 * EL_W + 2;
  // Four products plus a 33-bit accumulator fit with margin in ACC_W+4 bits.
  localparam int SUM_W  = ACC_W + 4;

  localparam logic signed [SUM_W-1:0] S_HI =
    {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] S_LO =
    {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] U_HI =
    {{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};

  logic sgn_a;
  logic sgn_b;
  assign sgn_a = first_is_signed(mode);
  assign sgn_b = second_is_signed(mode);

  logic signed [PROD_W-1:0] prod [EPL];

  for (genvar k = 0; k < EPL; k++) begin : g_pair
    logic signed [EL_W:0] ax;
    logic signed [EL_W:0] bx;
    assign ax = {sgn_a & a_bytes[k*EL_W+EL_W-1], a_bytes[k*EL_W +: EL_W]};
    assign bx = {sgn_b & b_bytes[k*EL_W+EL_W-1], b_bytes[k*EL_W +: EL_W]};
    assign prod[k] = ax * bx;
  end

  logic signed [SUM_W-1:0] total;

  always_comb begin
    // The accumulator is signed whenever the first operand is.
    total = {{(SUM_W-ACC_W){sgn_a & acc[ACC_W-1]}}, acc};
    for (int k = 0; k < EPL; k++) begin
      total = total + {{(SUM_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end
  end

  always_comb begin
    if (!active) begin
      result = '0;
    end else if (!sat_en) begin
      result = total[ACC_W-1:0];
    end else if (sgn_a) begin
      if (total > S_HI)      result = S_HI[ACC_W-1:0];
      else if (total < S_LO) result = S_LO[ACC_W-1:0];
      else                   result = total[ACC_W-1:0];
    end else begin
      if (total > U_HI)                result = '1;
      else if (total[SUM_W-1])         result = '0;
      else                             result = total[ACC_W-1:0];
    end
  end

  assign wrap_sum = active ? total[ACC_W-1:0] : '0;

endmodule

// File: rtl/pdp_out_stage.sv
module pdp_out_stage #(
  parameter int W   = 256,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (REG) begin : g_reg
    logic         v_q;
    logic [W-1:0] d_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (in_ready) begin
        v_q <= in_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) begin
        d_q <= in_data;
      end
    end

    assign out_valid = v_q;
    assign out_data  = d_q;

    // R10: a stalled result is held
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: an empty register always accepts
    assert_ready_when_empty_R9: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

    // R9: a taken beat shows up as a valid result next cycle
    assert_take_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);

    // R11: leaving reset finds the register empty
    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !out_valid);
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/pdp_dot_acc.sv
module pdp_dot_acc
  import pdp_pkg::*;
#(
  parameter int LANES        = 8,
  parameter int NARROW_LANES = 4,
  parameter int EL_W         = 8,
  parameter int EPL          = 4,
  parameter int ACC_W        = 32,
  parameter bit OUT_REG      = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [1:0]               mode,
  input  logic                     sat_en,
  input  logic                     wide,
  input  logic [LANES*ACC_W-1:0]   acc_in,
  input  logic [LANES*EPL*EL_W-1:0] a_in,
  input  logic [LANES*EPL*EL_W-1:0] b_in,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*ACC_W-1:0]   out_data
);

  localparam int LANE_BW = EPL * EL_W;
  localparam int ACC_VW  = LANES * ACC_W;
  localparam logic [ACC_W-1:0] SMAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SMIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0]  lane_res  [LANES];
  logic [ACC_W-1:0]  lane_wrap [LANES];
  logic [ACC_VW-1:0] comb_data;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic act;
    if (j < NARROW_LANES) begin : g_low
      assign act = 1'b1;
    end else begin : g_high
      assign act = wide;

      // R8: lanes above the narrow width produce zero
      assert_narrow_zero_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && !wide |-> (lane_res[j] == '0) && (lane_wrap[j] == '0));
    end

    pdp_lane #(
      .EL_W (EL_W),
      .EPL  (EPL),
      .ACC_W(ACC_W)
    ) u_lane (
      .mode    (mode),
      .sat_en  (sat_en),
      .active  (act),
      .acc     (acc_in[j*ACC_W +: ACC_W]),
      .a_bytes (a_in[j*LANE_BW +: LANE_BW]),
      .b_bytes (b_in[j*LANE_BW +: LANE_BW]),
      .wrap_sum(lane_wrap[j]),
      .result  (lane_res[j])
    );

    assign comb_data[j*ACC_W +: ACC_W] = lane_res[j];

    // R6: a signed saturating result that departs from the wrapped sum is a bound
    assert_signed_clamp_R6: assert property (@(posedge clk) disable iff (rst)
      in_valid && sat_en && !mode[1] && (lane_res[j] != lane_wrap[j])
      |-> (lane_res[j] == SMAX) || (lane_res[j] == SMIN));

    // R7: an unsigned saturating result that departs from the wrapped sum is all ones
    assert_unsigned_clamp_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid && sat_en && mode[1] && (lane_res[j] != lane_wrap[j])
      |-> (lane_res[j] == '1));

    // R7: unsigned products never lower an active unsigned accumulator
    assert_unsigned_monotone_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid && sat_en && mode[1] && act
      |-> (lane_res[j] >= acc_in[j*ACC_W +: ACC_W]));
  end

  pdp_out_stage #(
    .W  (ACC_VW),
    .REG(OUT_REG)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (comb_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

endmodule

// File: tb/tb_pdp_dot_acc.sv
module tb_pdp_dot_acc;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [1:0] mode = 2'b00;
  logic sat_en = 1'b0;
  logic wide = 1'b1;
  logic [VW-1:0] acc_in = '0;
  logic [VW-1:0] a_in = '0;
  logic [VW-1:0] b_in = '0;
  logic in_ready, out_valid;
  logic [VW-1:0] out_data;
  logic c_in_ready, c_out_valid;
  logic [VW-1:0] c_out_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdp_dot_acc dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .sat_en(sat_en), .wide(wide),
    .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  pdp_dot_acc #(.OUT_REG(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .mode(mode), .sat_en(sat_en), .wide(wide),
    .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
    .out_valid(c_out_valid), .out_ready(1'b1), .out_data(c_out_data)
  );

  // Stimulus table: {mode[1:0], sat_en, wide, seed[31:0]}
  localparam logic [35:0] TABLE [12] = '{
    36'h1_1234ABCD, 36'h3_0BADF00D, 36'h5_CAFE1234, 36'h7_55AA33CC,
    36'h9_DEADBEEF, 36'hB_FFFF0001, 36'hF_80000001, 36'hD_13579BDF,
    36'h2_2468ACE0, 36'h4_7FFF8000, 36'hA_F0F0F0F0, 36'h0_0F1E2D3C
  };

  function automatic logic [31:0] xs32(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return (y == 0) ? 32'h1 : y;
  endfunction

  function automatic logic [VW-1:0] spread(input logic [31:0] seed);
    logic [VW-1:0] v;
    logic [31:0] s;
    s = xs32(seed);
    for (int i = 0; i < VW/32; i++) begin
      s = xs32(s);
      v[i*32 +: 32] = s;
    end
    return v;
  endfunction

  // Behavioural reference for one lane, using 64-bit integer arithmetic.
  function automatic logic [31:0] ref_lane(input logic [1:0] m, input logic s,
      input logic [31:0] acc, input logic [31:0] a, input logic [31:0] b);
    longint t;
    longint x;
    longint y;
    bit a_s;
    bit b_s;
    a_s = (m == 2'b00) || (m == 2'b01);
    b_s = (m == 2'b00);
    t = a_s ? longint'($signed(acc)) : longint'({32'b0, acc});
    for (int k = 0; k < 4; k++) begin
      x = a_s ? longint'($signed(a[8*k +: 8])) : longint'({56'b0, a[8*k +: 8]});
      y = b_s ? longint'($signed(b[8*k +: 8])) : longint'({56'b0, b[8*k +: 8]});
      t = t + x * y;
    end
    if (s && a_s) begin
      if (t > 64'sd2147483647) t = 64'sd2147483647;
      if (t < -64'sd2147483648) t = -64'sd2147483648;
    end else if (s) begin
      if (t > 64'sd4294967295) t = 64'sd4294967295;
      if (t < 0) t = 0;
    end
    return t[31:0];
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [1:0] m, input logic s,
      input logic w, input logic [VW-1:0] acc, input logic [VW-1:0] a,
      input logic [VW-1:0] b);
    logic [VW-1:0] r;
    for (int j = 0; j < 8; j++) begin
      r[j*32 +: 32] = (!w && j >= 4) ? 32'h0
                      : ref_lane(m, s, acc[j*32 +: 32], a[j*32 +: 32], b[j*32 +: 32]);
    end
    return r;
  endfunction

  task automatic chk(input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic chk1(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic s, input logic w,
      input logic [VW-1:0] acc, input logic [VW-1:0] a, input logic [VW-1:0] b);
    mode = m; sat_en = s; wide = w; acc_in = acc; a_in = a; b_in = b;
    in_valid = 1'b1;
  endtask

  // One beat through both builds; checks the pass-through output in the
  // same cycle and the registered output after the capturing edge.
  task automatic run_case(input string tag, input logic [1:0] m, input logic s,
      input logic w, input logic [VW-1:0] acc, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input logic [VW-1:0] exp);
    @(negedge clk);
    out_ready = 1'b1;
    drive(m, s, w, acc, a, b);
    #1;
    chk({tag, " R12 same-cycle"}, c_out_data, exp);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk1({tag, " R9 out_valid"}, out_valid, 1'b1);
    chk({tag, " registered"}, out_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] va, vb, vc, ex1, ex2;

    repeat (3) @(negedge clk);
    chk1("R11 out_valid in reset", out_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk1("R11 out_valid after reset", out_valid, 1'b0);
    chk1("R9 in_ready when empty", in_ready, 1'b1);
    chk1("R12 in_ready follows out_ready", c_in_ready, 1'b1);
    chk1("R12 out_valid follows in_valid", c_out_valid, 1'b0);

    // Table walk against the reference model
    for (int i = 0; i < 12; i++) begin
      vc = spread(TABLE[i][31:0]);
      va = spread(TABLE[i][31:0] ^ 32'h9E3779B9);
      vb = spread(TABLE[i][31:0] + 32'h6A09E667);
      run_case($sformatf("table %0d R2 R3 R4 R5 R6 R7 R8", i),
               TABLE[i][35:34], TABLE[i][33], TABLE[i][32], vc, va, vb,
               ref_vec(TABLE[i][35:34], TABLE[i][33], TABLE[i][32], vc, va, vb));
    end

    // R1: byte placement and lane isolation
    run_case("R1 byte pairing", 2'b00, 1'b0, 1'b1, '0,
             {192'b0, 32'h00000005, 32'h04030201},
             {192'b0, 32'h00000007, 32'h40302010},
             {192'b0, 32'h00000023, 32'h000001E0});

    // Hand-computed corners, same value in every lane
    run_case("R6 s*s sat high", 2'b00, 1'b1, 1'b1, {8{32'h7FFFFFFF}},
             {32{8'h80}}, {32{8'h80}}, {8{32'h7FFFFFFF}});
    run_case("R5 s*s wrap high", 2'b00, 1'b0, 1'b1, {8{32'h7FFFFFFF}},
             {32{8'h80}}, {32{8'h80}}, {8{32'h8000FFFF}});
    run_case("R6 s*u sat low", 2'b01, 1'b1, 1'b1, {8{32'h80000000}},
             {32{8'h80}}, {32{8'hFF}}, {8{32'h80000000}});
    run_case("R5 s*u wrap low", 2'b01, 1'b0, 1'b1, {8{32'h80000000}},
             {32{8'h80}}, {32{8'hFF}}, {8{32'h7FFE0200}});
    run_case("R6 s*s sat low", 2'b00, 1'b1, 1'b1, {8{32'h80000000}},
             {32{8'h80}}, {32{8'h7F}}, {8{32'h80000000}});
    run_case("R6 s*u signed accumulator", 2'b01, 1'b1, 1'b1, {8{32'hFFFFFFFF}},
             {32{8'h01}}, {32{8'hFF}}, {8{32'h000003FB}});
    run_case("R7 u*u sat", 2'b10, 1'b1, 1'b1, {8{32'hFFFFFFFF}},
             {32{8'hFF}}, {32{8'hFF}}, {8{32'hFFFFFFFF}});
    run_case("R5 u*u wrap", 2'b10, 1'b0, 1'b1, {8{32'hFFFFFFFF}},
             {32{8'hFF}}, {32{8'hFF}}, {8{32'h0003F803}});
    run_case("R2 s*s minus one", 2'b00, 1'b0, 1'b1, '0,
             {32{8'hFF}}, {32{8'hFF}}, {8{32'h00000004}});
    run_case("R3 s*u mixed", 2'b01, 1'b0, 1'b1, '0,
             {32{8'hFF}}, {32{8'hFF}}, {8{32'hFFFFFC04}});
    run_case("R4 u*u code 10", 2'b10, 1'b0, 1'b1, '0,
             {32{8'hFF}}, {32{8'hFF}}, {8{32'h0003F804}});
    run_case("R4 u*u code 11", 2'b11, 1'b0, 1'b1, '0,
             {32{8'hFF}}, {32{8'hFF}}, {8{32'h0003F804}});
    run_case("R8 narrow width", 2'b10, 1'b1, 1'b0, {8{32'hFFFFFFFF}},
             {32{8'hFF}}, {32{8'hFF}}, {{4{32'h0}}, {4{32'hFFFFFFFF}}});

    // R10: stall with a second beat waiting
    ex1 = {8{32'h00000004}};
    ex2 = {8{32'h0003F804}};
    @(negedge clk);
    out_ready = 1'b0;
    drive(2'b00, 1'b0, 1'b1, '0, {32{8'hFF}}, {32{8'hFF}});
    @(posedge clk);
    @(negedge clk);
    drive(2'b10, 1'b0, 1'b1, '0, {32{8'hFF}}, {32{8'hFF}});
    chk1("R10 valid during stall", out_valid, 1'b1);
    chk1("R9 not ready during stall", in_ready, 1'b0);
    chk("R10 data during stall", out_data, ex1);
    repeat (2) @(negedge clk);
    chk("R10 data held after waiting", out_data, ex1);
    chk1("R10 valid held after waiting", out_valid, 1'b1);
    out_ready = 1'b1;
    #1;
    chk1("R9 ready when drained", in_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second beat after stall", out_data, ex2);
    @(negedge clk);
    chk1("R9 empty after drain", out_valid, 1'b0);

    // R11: reset while a result is held
    @(negedge clk);
    out_ready = 1'b0;
    drive(2'b00, 1'b0, 1'b1, '0, {32{8'h01}}, {32{8'h01}});
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk1("R11 valid before reset", out_valid, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk1("R11 reset clears valid", out_valid, 1'b0);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk1("R11 stays empty", out_valid, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule